// File: doc/BRIEF.md
# Dual-Port Sample Interleaver Front-End

This block sits in front of a converter that needs one code word on every clock. Upstream logic can run at half that rate by presenting two words at a time, one on port A and one on port B. The block captures each pair on a half-rate load event and emits A and then B. The result is a full-rate stream. Two other modes are selected by the same field. One passes a single port straight through. In that mode the port can be picked afresh on every clock.

A three-bit static field selects the mode. Two interleave modes take their load event from a one-cycle phase pulse supplied by a separate divider block; one of them also exports that phase. A third interleave mode takes its load event from an external half-rate strobe level, which it first registers. An inversion control can complement the output code. A valid flag tells the consumer when the pipeline for the current mode holds real data.

Top module: `ilv_front`

## Requirements
- R1: `mode_cfg_i` is read as a three-bit value, most significant bit first. 3'b000 selects interleave on the phase pulse with the phase exported. 3'b001 selects interleave on the phase pulse without export. 3'b010 selects interleave on the external strobe. 3'b100 selects pass-through of port A and 3'b110 pass-through of port B.
- R2: In every interleave mode, the port A word captured at a load edge is on `code_o` after the second rising clock edge following the load edge.
- R3: The port B word of the same pair follows on `code_o` one clock after the A word, as long as no further load edge falls on the clock right after the original load edge. A steady load every second clock therefore gives an unbroken A, B, A, B stream.
- R4: In external-strobe mode, `ext_strobe_i` is registered on every clock. A load edge is a clock edge at which `ext_strobe_i` is sampled high while the registered copy from the previous edge is low.
- R5: In the pass-through modes, the selected port sampled at a clock edge is on `code_o` right after that edge. Bit 1 of `mode_cfg_i`, sampled at the same edge, picks port B when 1 and port A when 0. It may change on every clock.
- R6: When `inv_n_i` is sampled low at the output edge, `code_o` is the bitwise complement of the selected word. When it is sampled high, the word passes unchanged.
- R7: The unlisted codes 3'b011, 3'b101 and 3'b111 behave as pass-through of port A.
- R8: While `rst_n` is low, `code_o` is all zeros and `valid_o` and `half_tap_o` are low.
- R9: In the pass-through modes, `valid_o` is high after every edge. In the interleave modes, `valid_o` goes low at an edge where the mode class changes, or at the first edge after reset. It goes high after the second edge following the first load edge at or after that change. Toggling bit 1 between 3'b100 and 3'b110 is not a change of class.
- R10: In mode 3'b000, `half_tap_o` repeats `half_phase_i` one clock later. In every other mode, `half_tap_o` is low.
- R11: `ext_strobe_i` has no effect on `code_o` in the phase-pulse modes. `half_phase_i` has no effect on `code_o` in external-strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg_i | input | 3 | Mode field; bit 1 doubles as the per-clock port select in pass-through |
| half_phase_i | input | 1 | One-cycle load pulse from the external divider |
| ext_strobe_i | input | 1 | Half-rate strobe level for external-strobe mode |
| inv_n_i | input | 1 | Low complements the output code |
| port_a_i | input | W | Sample port A |
| port_b_i | input | W | Sample port B |
| code_o | output | W | Registered output code stream |
| valid_o | output | 1 | Pipeline for the current mode holds captured data |
| half_tap_o | output | 1 | Exported phase pulse in mode 3'b000 |

## Verification
The B word path is the hardest case to reach. B is only observable when a load edge is not followed by another load on the very next clock. The bench drives irregular phase-pulse patterns that place gaps and back-to-back pulses together, and it predicts the output only from the load history of the last four edges. Valid clearing is reached by moving between interleave classes and pass-through in the middle of a run. Toggling the select bit during pass-through shows that this does not clear the flag. The phase-pulse and strobe inputs are driven with random activity in the modes that must ignore them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   localparam int ILV_PORTS = 2;
   localparam int PORT_A    = 0;
   localparam int PORT_B    = 1;

   typedef enum logic [1:0] {
      CLS_HALF_EXP = 2'd0,
      CLS_HALF     = 2'd1,
      CLS_STROBE   = 2'd2,
      CLS_PASS     = 2'd3
   } ilv_cls_e;

   localparam logic [2:0] CFG_HALF_EXP = 3'b000;
   localparam logic [2:0] CFG_HALF     = 3'b001;
   localparam logic [2:0] CFG_STROBE   = 3'b010;
   localparam logic [2:0] CFG_PASS_B   = 3'b110;

   function automatic ilv_cls_e cfg_to_cls(input logic [2:0] cfg);
      ilv_cls_e c;
      case (cfg)
         CFG_HALF_EXP: c = CLS_HALF_EXP;
         CFG_HALF:     c = CLS_HALF;
         CFG_STROBE:   c = CLS_STROBE;
         default:      c = CLS_PASS;
      endcase
      return c;
   endfunction

   function automatic logic cfg_picks_b(input logic [2:0] cfg);
      return (cfg == CFG_PASS_B);
   endfunction

endpackage

// File: rtl/ilv_mode_dec.sv
module ilv_mode_dec
   import ilv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cfg_i,
   output ilv_cls_e   cls_o,
   output logic       sel_b_o,
   output logic       cls_chg_o
);

   ilv_cls_e cls_q;

   always_comb begin
      cls_o   = cfg_to_cls(cfg_i);
      sel_b_o = cfg_picks_b(cfg_i);
   end

   // reset value makes the first edge in an interleave class look like a change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cls_q <= CLS_PASS;
      else        cls_q <= cls_o;
   end

   assign cls_chg_o = (cls_o != cls_q);

endmodule

// File: rtl/ilv_strobe_gen.sv
module ilv_strobe_gen
   import ilv_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ilv_cls_e cls_i,
   input  logic     half_phase_i,
   input  logic     ext_strobe_i,
   output logic     load_o,
   output logic     load_d1_o,
   output logic     half_tap_o
);

   logic strb_q;
   logic load_q;
   logic tap_q;

   always_comb begin
      case (cls_i)
         CLS_HALF_EXP,
         CLS_HALF:   load_o = half_phase_i;
         CLS_STROBE: load_o = ext_strobe_i & ~strb_q;
         default:    load_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
         load_q <= 1'b0;
         tap_q  <= 1'b0;
      end else begin
         strb_q <= ext_strobe_i;
         load_q <= load_o;
         tap_q  <= (cls_i == CLS_HALF_EXP) & half_phase_i;
      end
   end

   assign load_d1_o  = load_q;
   assign half_tap_o = tap_q;

endmodule

// File: rtl/ilv_capture.sv
module ilv_capture
   import ilv_pkg::*;
#(
   parameter int W = 10
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_i,
   input  logic                           load_d1_i,
   input  logic [ILV_PORTS-1:0][W-1:0]    port_i,
   output logic [W-1:0]                   mid_o
);

   logic [ILV_PORTS-1:0][W-1:0] cap_q;
   logic [W-1:0]                mid_q;

   for (genvar p = 0; p < ILV_PORTS; p++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cap_q[p] <= '0;
         else if (load_i) cap_q[p] <= port_i[p];
      end
   end

   // A right after a load; otherwise B, read before a new pair can land
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mid_q <= '0;
      else        mid_q <= load_d1_i ? cap_q[PORT_A] : cap_q[PORT_B];
   end

   assign mid_o = mid_q;

endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage
   import ilv_pkg::*;
#(
   parameter int W      = 10,
   parameter bit INV_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  ilv_cls_e      cls_i,
   input  logic          cls_chg_i,
   input  logic          sel_b_i,
   input  logic          inv_n_i,
   input  logic [W-1:0]  port_a_i,
   input  logic [W-1:0]  port_b_i,
   input  logic [W-1:0]  mid_i,
   input  logic          load_i,
   input  logic          load_d1_i,
   output logic [W-1:0]  code_o,
   output logic          valid_o
);

   logic          is_pass;
   logic [W-1:0]  pick;
   logic [W-1:0]  shaped;
   logic [W-1:0]  code_q;
   logic          cap_vld_q;
   logic          mid_vld_q;
   logic          out_vld_q;

   assign is_pass = (cls_i == CLS_PASS);

   always_comb begin
      if (is_pass) pick = sel_b_i ? port_b_i : port_a_i;
      else         pick = mid_i;
   end

   if (INV_EN) begin : g_inv
      assign shaped = inv_n_i ? pick : ~pick;
   end else begin : g_no_inv
      logic unused_inv;
      assign unused_inv = inv_n_i;
      assign shaped     = pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= shaped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_vld_q <= 1'b0;
         mid_vld_q <= 1'b0;
         out_vld_q <= 1'b0;
      end else begin
         cap_vld_q <= cls_chg_i ? load_i : (cap_vld_q | load_i);
         mid_vld_q <= cls_chg_i ? 1'b0   : (mid_vld_q | (cap_vld_q & load_d1_i));
         if (is_pass)        out_vld_q <= 1'b1;
         else if (cls_chg_i) out_vld_q <= 1'b0;
         else                out_vld_q <= mid_vld_q;
      end
   end

   assign code_o  = code_q;
   assign valid_o = out_vld_q;

endmodule

// File: rtl/ilv_front.sv
module ilv_front
   import ilv_pkg::*;
#(
   parameter int W      = 10,
   parameter bit INV_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode_cfg_i,
   input  logic          half_phase_i,
   input  logic          ext_strobe_i,
   input  logic          inv_n_i,
   input  logic [W-1:0]  port_a_i,
   input  logic [W-1:0]  port_b_i,
   output logic [W-1:0]  code_o,
   output logic          valid_o,
   output logic          half_tap_o
);

   localparam int PAIR_W = ILV_PORTS * W;

   if (W < 2 || W > 32) begin : g_bad_width
      $error("ilv_front: W must lie in 2..32");
   end
   if (PAIR_W != 2 * W) begin : g_bad_ports
      $error("ilv_front: datapath assumes exactly two ports");
   end

   ilv_cls_e       cls;
   logic           sel_b;
   logic           cls_chg;
   logic           load;
   logic           load_d1;
   logic [W-1:0]   mid;

   ilv_mode_dec u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (mode_cfg_i),
      .cls_o     (cls),
      .sel_b_o   (sel_b),
      .cls_chg_o (cls_chg)
   );

   ilv_strobe_gen u_strb (
      .clk          (clk),
      .rst_n        (rst_n),
      .cls_i        (cls),
      .half_phase_i (half_phase_i),
      .ext_strobe_i (ext_strobe_i),
      .load_o       (load),
      .load_d1_o    (load_d1),
      .half_tap_o   (half_tap_o)
   );

   ilv_capture #(.W(W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .load_d1_i (load_d1),
      .port_i    ({port_b_i, port_a_i}),
      .mid_o     (mid)
   );

   ilv_out_stage #(.W(W), .INV_EN(INV_EN)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cls_i     (cls),
      .cls_chg_i (cls_chg),
      .sel_b_i   (sel_b),
      .inv_n_i   (inv_n_i),
      .port_a_i  (port_a_i),
      .port_b_i  (port_b_i),
      .mid_i     (mid),
      .load_i    (load),
      .load_d1_i (load_d1),
      .code_o    (code_o),
      .valid_o   (valid_o)
   );

endmodule

// File: rtl/ilv_front_chk.sv
module ilv_front_chk #(
   parameter int W = 10
)(
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mode_cfg_i,
   input logic          half_phase_i,
   input logic          inv_n_i,
   input logic [W-1:0]  port_a_i,
   input logic [W-1:0]  port_b_i,
   input logic [W-1:0]  code_o,
   input logic          valid_o,
   input logic          half_tap_o
);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_rst_zero_r8: assert (code_o == '0 && !valid_o && !half_tap_o);
      end
   end

   p_pass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b100 && inv_n_i) |=> code_o == $past(port_a_i));

   p_pass_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b110 && inv_n_i) |=> code_o == $past(port_b_i));

   p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b100 && !inv_n_i) |=> code_o == ~$past(port_a_i));

   p_unlisted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b111 && inv_n_i) |=> code_o == $past(port_a_i));

   p_ilv_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (half_phase_i && mode_cfg_i == 3'b001) |-> ##3
      (!$past(mode_cfg_i == 3'b001) || !$past(inv_n_i) || code_o == $past(port_a_i, 3)));

   p_ilv_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_phase_i && mode_cfg_i == 3'b001) |-> ##4
      ($past(half_phase_i, 3) || $past(mode_cfg_i, 3) != 3'b001 ||
       !$past(mode_cfg_i == 3'b001) || !$past(inv_n_i) || code_o == $past(port_b_i, 4)));

   p_valid_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b100) |=> valid_o);

   p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b001 && $past(mode_cfg_i) == 3'b100) |=> !valid_o);

   p_tap_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i != 3'b000) |=> !half_tap_o);

   p_tap_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg_i == 3'b000) |=> half_tap_o == $past(half_phase_i));

endmodule

bind ilv_front ilv_front_chk #(.W(W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_cfg_i   (mode_cfg_i),
   .half_phase_i (half_phase_i),
   .inv_n_i      (inv_n_i),
   .port_a_i     (port_a_i),
   .port_b_i     (port_b_i),
   .code_o       (code_o),
   .valid_o      (valid_o),
   .half_tap_o   (half_tap_o)
);

// File: tb/ilv_front_tb.sv
module ilv_front_tb;

   localparam int CLK_P = 10;
   localparam int W     = 10;
   localparam int HD    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [2:0]    cfg = 3'b100;
   logic          hp = 1'b0;
   logic          ext = 1'b0;
   logic          inv = 1'b1;
   logic [W-1:0]  pa = '0;
   logic [W-1:0]  pb = '0;
   logic [W-1:0]  code_o;
   logic          valid_o;
   logic          half_tap_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   string xtag = "";

   // model history, index 0 = newest edge
   logic [W-1:0] ha [HD];
   logic [W-1:0] hb [HD];
   logic [2:0]   hc [HD];
   logic         hi [HD];
   logic         hl [HD];
   logic         ext_prev = 1'b0;
   int           cls_prev = 3;
   int           first_ld = -1;
   int           ncyc = 0;

   ilv_front u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_cfg_i   (cfg),
      .half_phase_i (hp),
      .ext_strobe_i (ext),
      .inv_n_i      (inv),
      .port_a_i     (pa),
      .port_b_i     (pb),
      .code_o       (code_o),
      .valid_o      (valid_o),
      .half_tap_o   (half_tap_o)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic int cls_of(input logic [2:0] c);
      case (c)
         3'b000:  return 0;
         3'b001:  return 1;
         3'b010:  return 2;
         default: return 3;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cyc=%0d cfg=%b actual=%0d expected=%0d", req, ncyc, hc[0], act, exp);
      end
   endtask

   task automatic step();
      int           cn;
      logic         ldn;
      logic [W-1:0] ev;
      bit           def;
      bit           exp_v;
      string        rq;
      @(posedge clk);
      cn = cls_of(cfg);
      case (cn)
         0, 1:    ldn = hp;
         2:       ldn = ext & ~ext_prev;
         default: ldn = 1'b0;
      endcase
      ext_prev = ext;
      for (int i = HD-1; i > 0; i--) begin
         ha[i] = ha[i-1]; hb[i] = hb[i-1]; hc[i] = hc[i-1];
         hi[i] = hi[i-1]; hl[i] = hl[i-1];
      end
      ha[0] = pa; hb[0] = pb; hc[0] = cfg; hi[0] = inv; hl[0] = ldn;
      if (cn != cls_prev) first_ld = ldn ? ncyc : -1;
      else if (first_ld < 0 && ldn) first_ld = ncyc;
      cls_prev = cn;
      exp_v = (cn == 3) || (first_ld >= 0 && ncyc - first_ld >= 2);
      #(CLK_P/4);
      def = 1'b1;
      ev  = '0;
      if (cn == 3) begin
         ev = (hc[0] == 3'b110) ? hb[0] : ha[0];
         if (hc[0] == 3'b100 || hc[0] == 3'b110) rq = "R5";
         else                                    rq = "R7";
      end else if (hl[2]) begin
         ev = ha[2];
         rq = (cn == 2) ? "R2 R4" : "R2";
      end else if (hl[3]) begin
         ev = hb[3];
         rq = (cn == 2) ? "R3 R4" : "R3";
      end else begin
         def = 1'b0;
         rq  = "";
      end
      if (def) begin
         if (!hi[0]) begin
            ev = ~ev;
            rq = {rq, " R6"};
         end
         chk({rq, " ", xtag}, int'(code_o), int'(ev));
      end
      chk({"R9 ", xtag}, int'(valid_o), int'(exp_v));
      chk({"R10 ", xtag}, int'(half_tap_o), int'(hc[0] == 3'b000 && hp));
      ncyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < HD; i++) begin
         ha[i] = '0; hb[i] = '0; hc[i] = 3'b100; hi[i] = 1'b1; hl[i] = 1'b0;
      end
      #1 rst_n = 1'b0;
      pa = 10'h3a5; pb = 10'h15a; cfg = 3'b100;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      // R8: reset state
      chk("R8 code", int'(code_o), 0);
      chk("R8 valid", int'(valid_o), 0);
      chk("R8 tap", int'(half_tap_o), 0);
      rst_n = 1'b1;

      // R1 R5 R6: sweep every A code through pass-through, inversion on bit 3
      xtag = "R1";
      cfg = 3'b100;
      for (int v = 0; v < (1 << W); v++) begin
         pa  = W'(v);
         pb  = W'($urandom);
         inv = ~v[3];
         step();
      end
      // R5: per-clock port select, valid must stay high (R9)
      for (int k = 0; k < 200; k++) begin
         cfg = ($urandom_range(0, 1) == 1) ? 3'b110 : 3'b100;
         pa  = W'($urandom);
         pb  = W'($urandom);
         inv = ($urandom_range(0, 3) != 0);
         step();
      end
      // R7: unlisted codes
      xtag = "R7";
      for (int u = 0; u < 3; u++) begin
         cfg = (u == 0) ? 3'b011 : ((u == 1) ? 3'b101 : 3'b111);
         for (int k = 0; k < 40; k++) begin
            pa = W'($urandom); pb = W'($urandom);
            inv = ($urandom_range(0, 1) == 1);
            step();
         end
      end
      // R2 R3 R10 R11: phase-pulse modes with regular then irregular pulses
      xtag = "R11";
      for (int m = 0; m < 2; m++) begin
         cfg = (m == 0) ? 3'b000 : 3'b001;
         for (int k = 0; k < 80; k++) begin
            hp  = (k < 40) ? (k % 2 == 0) : ($urandom_range(0, 2) == 0);
            ext = ($urandom_range(0, 1) == 1);
            pa  = W'($urandom); pb = W'($urandom);
            inv = ($urandom_range(0, 4) != 0);
            step();
         end
      end
      // R4 R11: external strobe, period 2 then period 4, phase pulse random
      cfg = 3'b010;
      for (int k = 0; k < 120; k++) begin
         ext = (k < 60) ? (k % 2 == 0) : ((k % 4) < 2);
         hp  = ($urandom_range(0, 1) == 1);
         pa  = W'($urandom); pb = W'($urandom);
         inv = ($urandom_range(0, 4) != 0);
         step();
      end
      // R9: class changes mid-run clear and refill valid
      xtag = "R9";
      ext = 1'b0;
      for (int r = 0; r < 4; r++) begin
         cfg = (r % 2 == 0) ? 3'b100 : 3'b001;
         for (int k = 0; k < 9; k++) begin
            hp = (k % 3 == 1);
            pa = W'($urandom); pb = W'($urandom);
            inv = 1'b1;
            step();
         end
         cfg = 3'b000;
         for (int k = 0; k < 7; k++) begin
            hp = (k % 2 == 0);
            pa = W'($urandom); pb = W'($urandom);
            step();
         end
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule